// File: doc/BRIEF.md
# General-Purpose I/O Port with Interrupt Detection

This block is a 32-pin general-purpose I/O port behind a simple register bus. Software picks each pin's direction, drives output values from a data register and reads the live pin levels back through a pad status register. The pin inputs pass through a two-flop synchroniser before any logic looks at them.

Every pin can raise an interrupt flag on a low level, a high level, a rising edge or a falling edge, chosen by a 2-bit trigger field. A separate per-pin override forces detection on both edges. Flags collect in a status register that software clears by writing ones. A mask register gates the flags onto two interrupt outputs, one for the lower sixteen pins and one for the upper sixteen.

The register bus is single-cycle: a write takes effect at the clock edge where `bus_wr` is high, and `bus_rdata` follows `bus_addr` combinationally. All registers reset to zero under a synchronous active-low reset.

Top module: `gpio_irq_port`

## Requirements
- R1: While reset is held, every register reads 0, `pad_oe` is 0 and both interrupt outputs are low.
- R2: The data register (offset 0x00) drives `pad_out`, the direction register (offset 0x04) drives `pad_oe` with 1 meaning output, and a read of the data register returns the value last written.
- R3: The pad status register (offset 0x08) returns the pin levels through a two-flop synchroniser, so a change on `pad_in` shows in it two clock edges later.
- R4: Trigger code 00 flags a pin while its synchronised level is low and 01 flags it while it is high; a level flag that is cleared sets again on the next cycle while the level still holds.
- R5: Trigger code 10 flags a pin once on a low-to-high transition and 11 flags it once on a high-to-low transition; a steady level and the opposite transition set no flag.
- R6: A set bit in the edge-select register (offset 0x1C) makes its pin flag on both rising and falling edges and the pin's trigger field is ignored.
- R7: Configuration register 1 (offset 0x0C) holds the trigger fields of pins 0 to 15 and configuration register 2 (offset 0x10) those of pins 16 to 31; pin n uses bits [2*(n mod 16)+1 : 2*(n mod 16)].
- R8: Writing 1 to a bit of the status register (offset 0x18) clears that flag; writing 0 leaves it unchanged, and a flag never clears without such a write.
- R9: When a new event and a clearing write fall on the same cycle, the flag stays set.
- R10: `irq_lo` is high when any pin 0 to 15 has both its status flag and its mask bit (offset 0x14) set; `irq_hi` does the same for pins 16 to 31.
- R11: After software writes 0 to the mask register and all ones to the status register, neither interrupt output is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one register write per cycle |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pad_in | input | 32 | Asynchronous pin levels |
| pad_out | output | 32 | Output values for the pins |
| pad_oe | output | 32 | Output enable per pin, 1 = drive |
| irq_lo | output | 1 | Enabled pending flag among pins 0 to 15 |
| irq_hi | output | 1 | Enabled pending flag among pins 16 to 31 |

## Verification
Detection is tried with a steady high level, a steady low level, single rising and falling transitions and a pulse under the both-edge override. Holding a level after a clear tells level triggering from edge triggering. The opposite transition tells the rising code from the falling code. A high-level field with the override set tells whether the field is really ignored. Pins on each side of pin 16 show that the field placement and the split of the two interrupt outputs are right.

// File: rtl/gpio_irq_pkg.sv
// Package: shared register offsets and trigger codes for the GPIO port.
// Assumes a 32-bit data bus and byte offsets on a 5-bit address.
package gpio_irq_pkg;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_DATA  = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_DIR   = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_PAD   = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_CFG1  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_CFG2  = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_MASK  = 5'h14;
    localparam logic [ADDR_W-1:0] OFS_FLAG  = 5'h18;
    localparam logic [ADDR_W-1:0] OFS_BOTH  = 5'h1C;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'b00,
        TRIG_HIGH = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_FALL = 2'b11
    } trig_e;
endpackage

// File: rtl/gpio_pin_sync.sv
// Module: two-flop synchroniser for the pin inputs, plus one more stage
// holding the previous synchronised level for edge detection.
// Assumes pad_in is asynchronous; all flops reset to 0 so no false edge
// appears when reset is released with the pins low.
module gpio_pin_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] lvl,
    output logic [W-1:0] lvl_d
);
    logic [W-1:0] meta_q;

    // Purpose: move the pins into the clock domain and keep a delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            lvl    <= '0;
            lvl_d  <= '0;
        end else begin
            meta_q <= pad_in;
            lvl    <= meta_q;
            lvl_d  <= lvl;
        end
    end
endmodule

// File: rtl/gpio_trig_detect.sv
// Module: per-pin event detection from the synchronised level and its
// previous value. Each pin's 2-bit trigger code picks level or edge
// detection; a set bit in both_en overrides the code with both edges.
// Assumes trig holds pin n's code at bits [2n+1:2n].
module gpio_trig_detect
    import gpio_irq_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   lvl,
    input  logic [W-1:0]   lvl_d,
    input  logic [2*W-1:0] trig,
    input  logic [W-1:0]   both_en,
    output logic [W-1:0]   evt
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        trig_e code;
        assign code = trig_e'(trig[2*i +: 2]);

        // Purpose: decide whether pin i has an event this cycle.
        always_comb begin
            if (both_en[i]) begin
                evt[i] = lvl[i] ^ lvl_d[i];
            end else begin
                unique case (code)
                    TRIG_LOW:  evt[i] = ~lvl[i];
                    TRIG_HIGH: evt[i] = lvl[i];
                    TRIG_RISE: evt[i] = lvl[i] & ~lvl_d[i];
                    default:   evt[i] = ~lvl[i] & lvl_d[i];
                endcase
            end
        end

        // R6: under the override a steady level yields no event whatever the field.
        p_both_steady_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (both_en[i] && (lvl[i] == lvl_d[i])) |-> !evt[i]);
    end
endmodule

// File: rtl/gpio_flag_bank.sv
// Module: interrupt status flags. Events set flags; a write strobe with
// a bit pattern clears the flags whose bits are 1. An event on the same
// cycle as a clear wins.
module gpio_flag_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_en,
    input  logic [W-1:0] clr_bits,
    input  logic [W-1:0] evt,
    output logic [W-1:0] flags
);
    logic [W-1:0] clr_mask;
    assign clr_mask = clr_en ? clr_bits : '0;

    // Purpose: hold, clear and set the flags.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_mask) | evt;
    end

    // R8: without a clearing write no flag drops.
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_en |=> ((flags & $past(flags)) == $past(flags)));

    // R8: a cleared bit without a new event reads 0 afterwards.
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((flags & $past(clr_bits) & ~$past(evt)) == '0));

    // R9: an event always leaves its flag set.
    p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & $past(evt)) == $past(evt)));
endmodule

// File: rtl/gpio_irq_port.sv
// Module: top of the GPIO port. Holds the software registers, decodes the
// single-cycle register bus, and combines flags with the mask into one
// interrupt output per half of the port.
// Assumes NPINS equals the bus width and is even; each configuration
// register carries the 2-bit codes of one half of the pins.
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic              irq_lo,
    output logic              irq_hi
);
    localparam int HALF = NPINS / 2;

    logic [NPINS-1:0] data_q, dir_q, cfg1_q, cfg2_q, mask_q, both_q;
    logic [NPINS-1:0] lvl, lvl_d, evt, flags, pend;
    logic             flag_wr;

    // Purpose: software writes to the plain registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
            cfg1_q <= '0;
            cfg2_q <= '0;
            mask_q <= '0;
            both_q <= '0;
        end else if (bus_wr) begin
            unique case (bus_addr)
                OFS_DATA: data_q <= bus_wdata;
                OFS_DIR:  dir_q  <= bus_wdata;
                OFS_CFG1: cfg1_q <= bus_wdata;
                OFS_CFG2: cfg2_q <= bus_wdata;
                OFS_MASK: mask_q <= bus_wdata;
                OFS_BOTH: both_q <= bus_wdata;
                default:  ;
            endcase
        end
    end

    assign flag_wr = bus_wr && (bus_addr == OFS_FLAG);

    // Purpose: read mux; unmapped offsets read 0.
    always_comb begin
        unique case (bus_addr)
            OFS_DATA: bus_rdata = data_q;
            OFS_DIR:  bus_rdata = dir_q;
            OFS_PAD:  bus_rdata = lvl;
            OFS_CFG1: bus_rdata = cfg1_q;
            OFS_CFG2: bus_rdata = cfg2_q;
            OFS_MASK: bus_rdata = mask_q;
            OFS_FLAG: bus_rdata = flags;
            OFS_BOTH: bus_rdata = both_q;
            default:  bus_rdata = '0;
        endcase
    end

    gpio_pin_sync #(.W(NPINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .lvl    (lvl),
        .lvl_d  (lvl_d)
    );

    gpio_trig_detect #(.W(NPINS)) u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl     (lvl),
        .lvl_d   (lvl_d),
        .trig    ({cfg2_q, cfg1_q}),
        .both_en (both_q),
        .evt     (evt)
    );

    gpio_flag_bank #(.W(NPINS)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_en   (flag_wr),
        .clr_bits (bus_wdata),
        .evt      (evt),
        .flags    (flags)
    );

    assign pend    = flags & mask_q;
    assign irq_lo  = |pend[HALF-1:0];
    assign irq_hi  = |pend[NPINS-1:HALF];
    assign pad_out = data_q;
    assign pad_oe  = dir_q;

    // R10 / R11: with every mask bit clear no interrupt output rises.
    p_mask_gates_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> (!irq_lo && !irq_hi));

    // R1: the outputs are quiet in the cycle after a reset edge.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (pad_oe == '0 && !irq_lo && !irq_hi));
endmodule

// File: tb/sim_gpio_irq_port.sv
module sim_gpio_irq_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe;
    logic        irq_lo, irq_hi;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [31:0] ALL_HIGH = 32'h5555_5555;

    always #4 clk = ~clk;

    gpio_irq_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic quiet();
        wr(5'h0C, ALL_HIGH);
        wr(5'h10, ALL_HIGH);
        wr(5'h1C, 32'h0);
        wr(5'h14, 32'h0);
        pad_in = '0;
        idle(4);
        wr(5'h18, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 32; a += 4) begin
            if (a != 8) begin
                rd(5'(a), v);
                check("R1 register reset", v, 32'h0);
            end
        end
        check("R1 pad_oe reset", pad_oe, 32'h0);
        check("R1 irq reset", {30'h0, irq_hi, irq_lo}, 32'h0);
    endtask

    task automatic t_no_pending();
        wr(5'h14, 32'h0);
        wr(5'h18, 32'hFFFF_FFFF);
        idle(2);
        check("R11 no irq after init writes", {30'h0, irq_hi, irq_lo}, 32'h0);
    endtask

    task automatic t_data_dir();
        logic [31:0] v;
        wr(5'h00, 32'hA5A5_0F0F);
        wr(5'h04, 32'hFFFF_0000);
        check("R2 pad_out", pad_out, 32'hA5A5_0F0F);
        check("R2 pad_oe", pad_oe, 32'hFFFF_0000);
        rd(5'h00, v);
        check("R2 data readback", v, 32'hA5A5_0F0F);
    endtask

    task automatic t_pad_sync();
        logic [31:0] v;
        pad_in = 32'h0000_0300;
        idle(1);
        rd(5'h08, v);
        check("R3 pad status after one edge", v, 32'h0);
        idle(1);
        rd(5'h08, v);
        check("R3 pad status after two edges", v, 32'h0000_0300);
        pad_in = '0;
        idle(3);
    endtask

    task automatic t_level();
        logic [31:0] v;
        quiet();
        rd(5'h18, v);
        check("R4 no flag with high-level pins low", v, 32'h0);
        pad_in[20] = 1'b1;
        idle(3);
        rd(5'h18, v);
        check("R4 high level sets flag (R7 cfg2 pin 20)", v, 32'h0010_0000);
        wr(5'h18, 32'h0010_0000);
        rd(5'h18, v);
        check("R9 flag stays while level holds through clear", v, 32'h0010_0000);
        pad_in[20] = 1'b0;
        idle(3);
        wr(5'h18, 32'h0010_0000);
        rd(5'h18, v);
        check("R4 flag gone after level drops", v, 32'h0);
        wr(5'h0C, 32'h5555_5155);
        idle(1);
        rd(5'h18, v);
        check("R4 low level on pin 5 (R7 cfg1 bits 11:10)", v, 32'h0000_0020);
    endtask

    task automatic t_edges();
        logic [31:0] v;
        quiet();
        wr(5'h0C, 32'h5555_5595);
        wr(5'h10, 32'h5555_555D);
        pad_in[17] = 1'b1;
        idle(4);
        wr(5'h18, 32'hFFFF_FFFF);
        pad_in[3] = 1'b1;
        idle(3);
        rd(5'h18, v);
        check("R5 rising edge pin 3", v, 32'h0000_0008);
        wr(5'h18, 32'h0000_0008);
        idle(3);
        rd(5'h18, v);
        check("R5 steady high gives no new rise flag", v, 32'h0);
        pad_in[3] = 1'b0;
        idle(3);
        rd(5'h18, v);
        check("R5 falling on rise pin ignored", v, 32'h0);
        pad_in[17] = 1'b0;
        idle(3);
        rd(5'h18, v);
        check("R5 falling edge pin 17 (R7 cfg2 bits 3:2)", v, 32'h0002_0000);
    endtask

    task automatic t_both();
        logic [31:0] v;
        quiet();
        wr(5'h1C, 32'h0000_0100);
        pad_in[8] = 1'b1;
        idle(3);
        rd(5'h18, v);
        check("R6 rise under override", v, 32'h0000_0100);
        wr(5'h18, 32'h0000_0100);
        idle(3);
        rd(5'h18, v);
        check("R6 high-level field ignored", v, 32'h0);
        pad_in[8] = 1'b0;
        idle(3);
        rd(5'h18, v);
        check("R6 fall under override", v, 32'h0000_0100);
    endtask

    task automatic t_clear_irq();
        logic [31:0] v;
        quiet();
        wr(5'h1C, 32'h0010_0008);
        pad_in[3] = 1'b1;
        pad_in[20] = 1'b1;
        idle(3);
        rd(5'h18, v);
        check("R8 two flags set", v, 32'h0010_0008);
        check("R10 masked flags give no irq", {30'h0, irq_hi, irq_lo}, 32'h0);
        wr(5'h14, 32'h0010_0000);
        check("R10 upper mask raises irq_hi only", {30'h0, irq_hi, irq_lo}, 32'h2);
        wr(5'h14, 32'h0000_0008);
        check("R10 lower mask raises irq_lo only", {30'h0, irq_hi, irq_lo}, 32'h1);
        wr(5'h18, 32'h0000_0008);
        rd(5'h18, v);
        check("R8 write one clears only that flag", v, 32'h0010_0000);
        check("R10 irq_lo drops after clear", {31'h0, irq_lo}, 32'h0);
        wr(5'h18, 32'h0);
        rd(5'h18, v);
        check("R8 write zero keeps flags", v, 32'h0010_0000);
        wr(5'h14, 32'h0);
        pad_in = '0;
        idle(3);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        t_reset();
        rst_n = 1'b1;
        idle(1);
        t_no_pending();
        t_data_dir();
        t_pad_sync();
        t_level();
        t_edges();
        t_both();
        t_clear_irq();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule